// File: doc/BRIEF.md
# Configurable Serial Audio Transmitter

This block turns parallel left and right audio samples into a two-channel serial data stream. It does not generate any serial clocks. An external source drives the bit clock, the left/right clock and, when that mode is used, a word clock. The block detects their edges on a faster system clock and drives each data bit so that it is stable at the chosen sampling edge. Samples are sent in twos-complement form, most significant bit first, and the left channel always goes before the right channel.

Static configuration inputs set four things:
- which bit clock edge samples the data;
- whether a field starts at a left/right clock edge or at a rising word clock edge;
- whether the first data bit is held back one bit period;
- how many bits each field carries, from 4 to 24.

Fields can be packed back-to-back, and the bit clock may pause between fields.

A frame is a left and right sample pair. It is loaded through a valid/ready handshake into a hold register. When a left field starts, the hold register is copied into a working frame, and the right field of that same frame is taken from this copy. If no new frame has arrived by the time a left field starts, the previous frame is sent again.

Top module: `ser_audio_tx`

## Requirements
- R1: Each field sends the top `len` bits of its 24-bit sample, MSB first (bit 23 first). A field started while the left/right clock is high carries the left sample; a field started while it is low carries the right sample.
- R2: The field length `len` is `field_len_i`, limited to the range 4 to 24. A value below 4 acts as 4, and a value above 24 acts as 24.
- R3: When `lr_trig_i`=1, every change of the left/right clock seen at a launch edge starts a field. Without MSB delay, the MSB is the value present at the next sampling edge.
- R4: When `lr_trig_i`=0, a field starts only when the word clock has risen since the previous launch edge. The channel is taken from the left/right clock level at that edge. In this mode, changes of the left/right clock start nothing. When `lr_trig_i`=1, the word clock has no effect.
- R5: With `msb_dly_i`=1, the MSB appears one bit period after the trigger. During that one-bit slot the output carries the next remaining bit of the previous field, or 0 if that field has finished.
- R6: With `bclk_inv_i`=0, data changes only after falling bit clock edges and is sampled at rising edges. With `bclk_inv_i`=1, the two edges swap roles. `sdata_o` changes only in the cycle after a detected launch edge.
- R7: Once a field's `len` bits have been sent, `sdata_o` stays 0 until the next field's MSB.
- R8: A trigger that arrives while bits of the current field remain abandons those bits and starts the new field.
- R9: `smp_ready_o` is 1 when the hold register is free. When `smp_valid_i` and `smp_ready_o` are both 1, the frame is accepted and `smp_ready_o` goes to 0 in the next cycle. It returns to 1 after the right field of the frame that used the accepted data has been triggered. If no frame was accepted, the previous frame is repeated.
- R10: While in reset and after reset, `sdata_o`=0 and `smp_ready_o`=1.
- R11: The bit clock may stop between fields for any length of time. Output state is kept while it is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, several times faster than the bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bclk_i | input | 1 | Serial bit clock |
| lrclk_i | input | 1 | Left/right clock; 1 selects the left channel |
| wclk_i | input | 1 | Word clock, used when field start is set to word clock |
| bclk_inv_i | input | 1 | 0: sample on the rising edge; 1: sample on the falling edge |
| msb_dly_i | input | 1 | 1: hold the MSB back one bit period |
| lr_trig_i | input | 1 | 1: fields start at left/right clock changes; 0: fields start at word clock rises |
| field_len_i | input | 5 | Requested field length in bits |
| smp_valid_i | input | 1 | A frame is offered |
| smp_left_i | input | 24 | Left sample |
| smp_right_i | input | 24 | Right sample |
| smp_ready_o | output | 1 | The hold register can take a frame |
| sdata_o | output | 1 | Serial data out |

## Verification
The assertions assume the following about the inputs:
- The configuration inputs change only while no bits are outstanding.
- The serial clocks change slowly compared with the system clock.
- The left/right clock and the word clock change only together with a launch edge.

The stimulus follows these rules. It holds each bit clock phase for eight system cycles. It changes the left/right clock and the word clock in the same cycle as the launch transition. It changes the configuration only in idle gaps after enough trailing bits have flushed the previous field. It offers new frames only while the bit clock is paused at its sampling level, between frames.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;
  localparam int unsigned SMP_W   = 24;
  localparam int unsigned MIN_LEN = 4;
  localparam int unsigned LEN_W   = $clog2(SMP_W + 1);

  typedef logic [SMP_W-1:0] smp_t;

  typedef struct packed {
    smp_t left;
    smp_t right;
  } frame_t;
endpackage

// File: rtl/ser_tx_sync.sv
module ser_tx_sync #(
  parameter int unsigned N      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  localparam int unsigned CHAIN_W = N * STAGES;

  logic [CHAIN_W-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= d_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[CHAIN_W-N-1:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[CHAIN_W-1 -: N];
endmodule

// File: rtl/ser_tx_trig.sv
module ser_tx_trig (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bclk_s_i,
  input  logic lr_s_i,
  input  logic wclk_s_i,
  input  logic bclk_inv_i,
  input  logic lr_trig_i,
  output logic launch_o,
  output logic trig_o,
  output logic left_o
);
  logic bclk_q;
  logic lr_q;
  logic wclk_q;

  // launch edge is opposite to the sampling edge
  always_comb begin
    launch_o = bclk_inv_i ? (bclk_s_i & ~bclk_q) : (~bclk_s_i & bclk_q);
    trig_o   = launch_o & (lr_trig_i ? (lr_s_i ^ lr_q) : (wclk_s_i & ~wclk_q));
    left_o   = lr_s_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_q <= 1'b0;
      lr_q   <= 1'b0;
      wclk_q <= 1'b0;
    end else begin
      bclk_q <= bclk_s_i;
      if (launch_o) begin
        lr_q   <= lr_s_i;
        wclk_q <= wclk_s_i;
      end
    end
  end
endmodule

// File: rtl/ser_tx_buf.sv
module ser_tx_buf
  import ser_tx_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   valid_i,
  input  smp_t   left_i,
  input  smp_t   right_i,
  input  logic   trig_i,
  input  logic   trig_left_i,
  output logic   ready_o,
  output frame_t frame_o
);
  frame_t hold_q;
  frame_t cur_q;
  logic   busy_q;
  logic   taken_q;

  assign ready_o = ~busy_q;

  // left trigger reads the hold register directly so an undelayed MSB sees it
  always_comb frame_o = (trig_i & trig_left_i) ? hold_q : cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q  <= '0;
      cur_q   <= '0;
      busy_q  <= 1'b0;
      taken_q <= 1'b0;
    end else begin
      if (trig_i) begin
        if (trig_left_i) begin
          cur_q <= hold_q;
          if (busy_q) taken_q <= 1'b1;
        end else if (taken_q) begin
          busy_q  <= 1'b0;
          taken_q <= 1'b0;
        end
      end
      if (valid_i && !busy_q) begin
        hold_q  <= '{left: left_i, right: right_i};
        busy_q  <= 1'b1;
        taken_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ser_tx_shift.sv
module ser_tx_shift
  import ser_tx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             launch_i,
  input  logic             trig_i,
  input  logic             trig_left_i,
  input  logic             msb_dly_i,
  input  logic [LEN_W-1:0] len_i,
  input  frame_t           frame_i,
  output logic             sdata_o,
  output logic             load_o,
  output logic [LEN_W-1:0] bits_left_o
);
  smp_t             sh_q;
  logic [LEN_W-1:0] cnt_q;
  logic             pend_q;
  logic             pend_left_q;
  logic             sd_q;
  logic             now_ld;
  logic             ld_left;
  smp_t             ld_word;

  always_comb begin
    now_ld  = trig_i & ~msb_dly_i;
    load_o  = launch_i & (now_ld | pend_q);
    ld_left = now_ld ? trig_left_i : pend_left_q;
    ld_word = ld_left ? frame_i.left : frame_i.right;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q        <= '0;
      cnt_q       <= '0;
      pend_q      <= 1'b0;
      pend_left_q <= 1'b0;
      sd_q        <= 1'b0;
    end else if (launch_i) begin
      pend_q <= trig_i & msb_dly_i;
      if (trig_i) pend_left_q <= trig_left_i;
      if (load_o) begin
        sd_q  <= ld_word[SMP_W-1];
        sh_q  <= {ld_word[SMP_W-2:0], 1'b0};
        cnt_q <= len_i - LEN_W'(1);
      end else if (cnt_q != '0) begin
        sd_q  <= sh_q[SMP_W-1];
        sh_q  <= {sh_q[SMP_W-2:0], 1'b0};
        cnt_q <= cnt_q - LEN_W'(1);
      end else begin
        sd_q <= 1'b0;
      end
    end
  end

  assign sdata_o     = sd_q;
  assign bits_left_o = cnt_q;
endmodule

// File: rtl/ser_audio_tx.sv
module ser_audio_tx
  import ser_tx_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bclk_i,
  input  logic             lrclk_i,
  input  logic             wclk_i,
  input  logic             bclk_inv_i,
  input  logic             msb_dly_i,
  input  logic             lr_trig_i,
  input  logic [LEN_W-1:0] field_len_i,
  input  logic             smp_valid_i,
  input  logic [SMP_W-1:0] smp_left_i,
  input  logic [SMP_W-1:0] smp_right_i,
  output logic             smp_ready_o,
  output logic             sdata_o
);
  logic [2:0]       sync_q;
  logic             launch;
  logic             trig;
  logic             trig_left;
  logic             load;
  logic [LEN_W-1:0] bits_left;
  logic [LEN_W-1:0] len_eff;
  frame_t           frame;

  always_comb begin
    if (field_len_i < LEN_W'(MIN_LEN))    len_eff = LEN_W'(MIN_LEN);
    else if (field_len_i > LEN_W'(SMP_W)) len_eff = LEN_W'(SMP_W);
    else                                  len_eff = field_len_i;
  end

  ser_tx_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({bclk_i, lrclk_i, wclk_i}),
    .q_o    (sync_q)
  );

  ser_tx_trig u_trig (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bclk_s_i   (sync_q[2]),
    .lr_s_i     (sync_q[1]),
    .wclk_s_i   (sync_q[0]),
    .bclk_inv_i (bclk_inv_i),
    .lr_trig_i  (lr_trig_i),
    .launch_o   (launch),
    .trig_o     (trig),
    .left_o     (trig_left)
  );

  ser_tx_buf u_buf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (smp_valid_i),
    .left_i      (smp_left_i),
    .right_i     (smp_right_i),
    .trig_i      (trig),
    .trig_left_i (trig_left),
    .ready_o     (smp_ready_o),
    .frame_o     (frame)
  );

  ser_tx_shift u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .launch_i    (launch),
    .trig_i      (trig),
    .trig_left_i (trig_left),
    .msb_dly_i   (msb_dly_i),
    .len_i       (len_eff),
    .frame_i     (frame),
    .sdata_o     (sdata_o),
    .load_o      (load),
    .bits_left_o (bits_left)
  );
endmodule

// File: rtl/ser_audio_tx_chk.sv
module ser_audio_tx_chk
  import ser_tx_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             msb_dly_i,
  input logic             smp_valid_i,
  input logic             smp_ready_o,
  input logic             sdata_o,
  input logic             launch,
  input logic             trig,
  input logic             trig_left,
  input logic             load,
  input logic [LEN_W-1:0] bits_left
);
  assert_accept_ready_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_i && smp_ready_o |=> !smp_ready_o);

  assert_ready_rise_right_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(smp_ready_o) |-> $past(trig && !trig_left));

  assert_sdata_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !launch |=> $stable(sdata_o));

  assert_idle_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch && !load && (bits_left == '0) |=> !sdata_o);

  assert_trig_load_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig && !msb_dly_i |-> load);
endmodule

bind ser_audio_tx ser_audio_tx_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .msb_dly_i   (msb_dly_i),
  .smp_valid_i (smp_valid_i),
  .smp_ready_o (smp_ready_o),
  .sdata_o     (sdata_o),
  .launch      (launch),
  .trig        (trig),
  .trig_left   (trig_left),
  .load        (load),
  .bits_left   (bits_left)
);

// File: tb/sim_ser_audio_tx.sv
module sim_ser_audio_tx;
  localparam int CLK_PERIOD = 10;
  localparam int H          = 8;
  localparam int EXP_N      = 512;
  localparam int WDOG       = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bclk = 1'b1;
  logic        lrclk = 1'b0;
  logic        wclk = 1'b0;
  logic        bclk_inv = 1'b0;
  logic        msb_dly = 1'b0;
  logic        lr_trig = 1'b1;
  logic [4:0]  field_len = 5'd16;
  logic        valid = 1'b0;
  logic [23:0] sl = '0;
  logic [23:0] sr = '0;
  logic        ready;
  logic        sdata;

  int vecs = 0;
  int miss = 0;
  bit done = 1'b0;

  bit          exp_b [EXP_N];
  logic [23:0] m_hold_l = '0, m_hold_r = '0, m_cur_l = '0, m_cur_r = '0;
  bit          m_busy = 1'b0, m_lt = 1'b0;
  int          c_len = 16;
  bit          c_dly = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ser_audio_tx u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .bclk_i      (bclk),
    .lrclk_i     (lrclk),
    .wclk_i      (wclk),
    .bclk_inv_i  (bclk_inv),
    .msb_dly_i   (msb_dly),
    .lr_trig_i   (lr_trig),
    .field_len_i (field_len),
    .smp_valid_i (valid),
    .smp_left_i  (sl),
    .smp_right_i (sr),
    .smp_ready_o (ready),
    .sdata_o     (sdata)
  );

  task automatic chk(input string tag, input logic act, input logic expv);
    vecs++;
    if (act !== expv) begin
      miss++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, expv, $time);
    end
  endtask

  // offer a new frame if the model says the hold register is free
  task automatic offer_frame();
    logic [23:0] l;
    logic [23:0] r;
    l = 24'($urandom);
    r = 24'($urandom);
    if (m_busy) begin
      chk("R9 ready low while frame held", ready, 1'b0);
    end else begin
      chk("R9 ready high when free", ready, 1'b1);
      @(negedge clk);
      valid = 1'b1; sl = l; sr = r;
      @(negedge clk);
      valid = 1'b0;
      chk("R9 ready drops after accept", ready, 1'b0);
      m_hold_l = l; m_hold_r = r;
      m_busy = 1'b1; m_lt = 1'b0;
    end
  endtask

  // field triggered at launch before sampling edge g
  task automatic field_start(input int g, input bit left);
    logic [23:0] w;
    int          s;
    if (left) begin
      m_cur_l = m_hold_l; m_cur_r = m_hold_r;
      if (m_busy) m_lt = 1'b1;
    end else if (m_lt) begin
      m_busy = 1'b0; m_lt = 1'b0;
    end
    w = left ? m_cur_l : m_cur_r;
    s = g + (c_dly ? 1 : 0);
    for (int k = s; k < EXP_N; k++) exp_b[k] = 1'b0;
    for (int i = 0; i < c_len; i++)
      if (s + i < EXP_N) exp_b[s + i] = w[23 - i];
  endtask

  task automatic run(input string tag, input int nfr, input int len_cfg, input bit dly,
                     input bit lrm, input bit inv, input int slot, input int skip,
                     input bit gate, input bit noise, input bit reload);
    int  nbits;
    int  fr_bits;
    bit  launch_lvl;
    @(negedge clk);
    bclk_inv  = inv;
    msb_dly   = dly;
    lr_trig   = lrm;
    field_len = 5'(len_cfg);
    c_dly     = dly;
    c_len     = (len_cfg < 4) ? 4 : (len_cfg > 24) ? 24 : len_cfg;
    launch_lvl = inv;
    repeat (4) @(negedge clk);
    bclk = ~launch_lvl;
    repeat (6) @(negedge clk);
    for (int k = 0; k < EXP_N; k++) exp_b[k] = 1'b0;
    fr_bits = nfr * 2 * slot;
    nbits   = fr_bits + c_len + 4;
    for (int g = 0; g < nbits; g++) begin
      bit in_fr;
      int k;
      int sn;
      in_fr = (g < fr_bits);
      k  = g % slot;
      sn = g / slot;
      if (gate && in_fr && k == 0 && g > 0) repeat (3 * H) @(negedge clk);
      if (in_fr && (g % (2 * slot)) == 0 && (g == 0 || reload)) offer_frame();
      @(negedge clk);
      bclk  = launch_lvl;
      lrclk = in_fr ? ((sn % 2) == 0) : 1'b0;
      if (lrm) wclk = in_fr && noise && (k == 0 || k == 2);
      else     wclk = in_fr && (k == 0) && (sn != skip);
      if (in_fr && k == 0 && (lrm || sn != skip)) field_start(g, (sn % 2) == 0);
      repeat (H) @(negedge clk);
      chk(tag, sdata, exp_b[g]);
      if (in_fr && k == slot / 2) chk("R9 ready level mid field", ready, !m_busy);
      bclk = ~launch_lvl;
      repeat (H) @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 sdata in reset", sdata, 1'b0);
    chk("R10 ready in reset", ready, 1'b1);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R10 sdata after reset", sdata, 1'b0);
    chk("R10 ready after reset", ready, 1'b1);

    run("R1 R3 packed lr fields", 2, 16, 0, 1, 0, 16, -1, 0, 0, 1);
    run("R5 msb delay packed",    3, 16, 1, 1, 0, 16, -1, 0, 0, 1);
    run("R6 inverted bit clock",  2, 24, 0, 1, 1, 24, -1, 0, 0, 1);
    run("R2 R4 R11 min len word clock skip", 3, 2, 0, 0, 0, 8, 3, 1, 0, 1);
    run("R2 R8 R4 max len truncated repeat", 2, 30, 0, 1, 0, 20, -1, 0, 1, 0);
    run("R7 R5 R11 word clock delay idle",   2, 20, 1, 0, 1, 24, -1, 1, 0, 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      miss++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
    end
  end
endmodule